// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block sequences the modulus-control lines of an external multi-modulus prescaler. It is clocked once per prescaler output cycle. One divider cycle is built from up to four ratio phases, R1 to R4. Their lengths come from four programmable length fields, and a two-bit ratio mode selects which phases are present. When the last active phase ends, the block raises a one-cycle divider output pulse. On the same edge it adds a fractional step to an accumulator that wraps modulo 5 or modulo 8.

When the accumulator wraps, the following divider cycle moves one count out of R1 and into R2. Assuming R2 is one more than R1, the average division ratio gains step/Q. The accumulator contents are brought out for a downstream compensation circuit.

The length fields, ratio mode, step and modulus select are only taken in at a divider-cycle boundary, so reprogramming never breaks a cycle. A load-window output marks when those inputs may be changed safely. The sequencer has five states:
- IDLE, R1, R2, R3 and R4.
- START: IDLE to R1 when the block is enabled.
- ADVANCE: from the end of a phase to the next active phase.
- WRAP: from the end of the last phase back to R1.
- STOP: any state to IDLE when the enable drops.

Top module: `fn_main_divider`

## Requirements
- R1: While `div_en` is low (and after reset), the block stays in IDLE with `mod_ctl`=2'b10, `div_out`=0, `load_window`=0 and the accumulator cleared, so `frac_acc`=0.
- R2: Ratio mode selects the phases in a cycle: mode 00 gives R1,R2,R4; mode 01 gives R1,R2; mode 10 gives R1,R2,R3; mode 11 gives R1,R2,R3,R4. Phases always run in that order.
- R3: `mod_ctl` is 2'b10 in R1, 2'b00 in R2, 2'b01 in R3 and 2'b11 in R4.
- R4: Without a carry, R1 lasts `r1_len`+2 cycles, counting from -`r1_len`-1 up to 0. R2 lasts the effective R2 length. R3 lasts `r3_len`+1 cycles and R4 lasts `r4_len`+1 cycles. An R2 of zero length is skipped.
- R5: The effective R2 length is all 8 bits of `r2_len` in mode 01, and only bits [3:0] of `r2_len` in the other modes.
- R6: In a cycle that follows an accumulator carry, R1 is one cycle shorter (it ends at -1) and R2 is one cycle longer (it starts at 0). The total cycle length does not change.
- R7: `div_out` is high for exactly one clock, the final clock of each divider cycle.
- R8: At that final clock the accumulator adds the step reduced modulo Q, where Q=8 when `mod8_sel`=1 and Q=5 otherwise. The new value shows on `frac_acc` from the next clock onward. A sum of Q or more wraps and sets the carry used by the next cycle.
- R9: The configuration inputs are sampled only on the enabling edge and on the final edge of each divider cycle. A change made inside a cycle affects only the next cycle.
- R10: `load_window` is high during every clock of the last active phase except its final clock, and it is never high together with `div_out`.
- R11: Over any Q consecutive divider cycles with a fixed configuration, the number of R2 clocks equals Q times the effective R2 length plus the step modulo Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per counted cycle |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| div_en | input | 1 | Divider enable; low forces IDLE and clears the accumulator |
| r1_len | input | 12 | R1 phase length field |
| r2_len | input | 8 | R2 phase length field (4 bits used outside mode 01) |
| r3_len | input | 4 | R3 phase length field |
| r4_len | input | 4 | R4 phase length field |
| ratio_mode | input | 2 | Selects which phases form a cycle |
| frac_step | input | 3 | Fractional step added per divider cycle |
| mod8_sel | input | 1 | Accumulator modulus: 1 selects 8, 0 selects 5 |
| mod_ctl | output | 2 | Prescaler modulus-control lines |
| div_out | output | 1 | One-clock pulse at each divider-cycle end |
| frac_acc | output | 3 | Fractional accumulator contents |
| load_window | output | 1 | High while configuration inputs may be changed safely |

## Verification
The assertions check the following on every cycle:
- The output pulse is never stretched.
- The load window and the pulse never coincide.
- The R1 count never becomes positive, and stays negative in a carry cycle.
- R3 is only entered in a mode that has it.
- The accumulator stays below the modulus in force and clears while disabled.
- The working configuration changes only on a load edge.

The bench scenarios show the rest: the exact phase lengths in each ratio mode, the R2 width masking, skipping a zero-length R2, reduction of an oversized step, correct placement of the extra R2 count, and reprogramming inside a cycle. They also check the R2-clock total over a full modulus period against the expected fractional average.

// File: rtl/fn_pkg.sv
package fn_pkg;
    localparam int FN_L1_W  = 12;
    localparam int FN_L2_W  = 8;
    localparam int FN_LX_W  = 4;
    localparam int FN_ST_W  = 3;
    localparam int FN_CNT_W = FN_L1_W + 1;
    localparam int FN_Q_LONG  = 8;
    localparam int FN_Q_SHORT = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_R1,
        PH_R2,
        PH_R3,
        PH_R4
    } fn_phase_e;

    typedef struct packed {
        logic [FN_L1_W-1:0] len1;
        logic [FN_L2_W-1:0] len2;
        logic [FN_LX_W-1:0] len3;
        logic [FN_LX_W-1:0] len4;
        logic [1:0]         mode;
        logic [FN_ST_W-1:0] step;
        logic               mod8;
    } fn_cfg_t;
endpackage

// File: rtl/fn_frac_acc.sv
module fn_frac_acc
    import fn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               step,
    input  logic [FN_ST_W-1:0] inc,
    input  logic               mod8,
    output logic [FN_ST_W-1:0] acc,
    output logic               carry
);
    localparam int SW = FN_ST_W + 1;

    logic [SW-1:0] q;
    logic [SW-1:0] inc_r;
    logic [SW-1:0] acc_r;
    logic [SW-1:0] sum;
    logic [SW-1:0] nxt;

    always_comb begin
        q     = mod8 ? SW'(FN_Q_LONG) : SW'(FN_Q_SHORT);
        inc_r = ({1'b0, inc} >= q) ? ({1'b0, inc} - q) : {1'b0, inc};
        acc_r = ({1'b0, acc} >= q) ? ({1'b0, acc} - q) : {1'b0, acc};
        sum   = acc_r + inc_r;
        carry = (sum >= q);
        nxt   = carry ? (sum - q) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc <= '0;
        end else if (step) begin
            acc <= nxt[FN_ST_W-1:0];
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc == '0));                                   // R1
    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step) |=> ({1'b0, acc} < $past(q)));             // R8
endmodule

// File: rtl/fn_phase_seq.sv
module fn_phase_seq
    import fn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [FN_L2_W-1:0] len2_w,
    input  logic [FN_LX_W-1:0] len3_w,
    input  logic [FN_LX_W-1:0] len4_w,
    input  logic [1:0]         mode_w,
    input  logic [FN_L1_W-1:0] len1_nx,
    input  logic               carry_in,
    output logic [1:0]         mod_ctl,
    output logic               cyc_end,
    output logic               window,
    output logic               reload
);
    localparam logic signed [FN_CNT_W-1:0] ONE = FN_CNT_W'(1);

    fn_phase_e                    st, st_d, nx, aft2, aft3;
    logic signed [FN_CNT_W-1:0]   cnt, cnt_d, end_val, r1_start;
    logic                         ovf_r, ovf_d;
    logic [FN_L2_W-1:0]           len2_eff;
    logic                         has_r2, has_r3, has_r4, at_end;

    // phase bookkeeping
    always_comb begin
        len2_eff = (mode_w == 2'b01) ? len2_w
                 : {{(FN_L2_W-FN_LX_W){1'b0}}, len2_w[FN_LX_W-1:0]};
        has_r2   = ovf_r || (len2_eff != '0);
        has_r3   = mode_w[1];
        has_r4   = (mode_w[1] == mode_w[0]);
        aft3     = has_r4 ? PH_R4 : PH_IDLE;
        aft2     = has_r3 ? PH_R3 : aft3;
        r1_start = -$signed(FN_CNT_W'(len1_nx)) - ONE;
        unique case (st)
            PH_R1:   begin nx = has_r2 ? PH_R2 : aft2; end_val = ovf_r ? -ONE : '0; end
            PH_R2:   begin nx = aft2;    end_val = $signed(FN_CNT_W'(len2_eff)); end
            PH_R3:   begin nx = aft3;    end_val = $signed(FN_CNT_W'(len3_w));   end
            PH_R4:   begin nx = PH_IDLE; end_val = $signed(FN_CNT_W'(len4_w));   end
            default: begin nx = PH_IDLE; end_val = '0; end
        endcase
        at_end  = (st != PH_IDLE) && (cnt == end_val);
        cyc_end = at_end && (nx == PH_IDLE);
        reload  = en && ((st == PH_IDLE) || cyc_end);
    end

    // next state
    always_comb begin
        st_d  = st;
        cnt_d = cnt + ONE;
        ovf_d = ovf_r;
        if (!en) begin
            st_d = PH_IDLE; cnt_d = '0; ovf_d = 1'b0;           // STOP
        end else if (st == PH_IDLE) begin
            st_d = PH_R1; cnt_d = r1_start; ovf_d = 1'b0;       // START
        end else if (cyc_end) begin
            st_d = PH_R1; cnt_d = r1_start; ovf_d = carry_in;   // WRAP
        end else if (at_end) begin
            st_d  = nx;                                         // ADVANCE
            cnt_d = (nx == PH_R2 && !ovf_r) ? ONE : '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= PH_IDLE;
            cnt   <= '0;
            ovf_r <= 1'b0;
        end else begin
            st    <= st_d;
            cnt   <= cnt_d;
            ovf_r <= ovf_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            PH_R2:   mod_ctl = 2'b00;
            PH_R3:   mod_ctl = 2'b01;
            PH_R4:   mod_ctl = 2'b11;
            default: mod_ctl = 2'b10;
        endcase
        window = (st != PH_IDLE) && (nx == PH_IDLE) && !at_end;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> !cyc_end);                                  // R7
    AST_WINDOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_end && window));                                  // R10
    AST_R1_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_R1) |-> (cnt <= 0));                          // R4
    AST_R1_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_R1 && ovf_r) |-> (cnt < 0));                  // R6
    AST_R3_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_R3) |-> mode_w[1]);                           // R2
endmodule

// File: rtl/fn_main_divider.sv
module fn_main_divider
    import fn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_en,
    input  logic [FN_L1_W-1:0] r1_len,
    input  logic [FN_L2_W-1:0] r2_len,
    input  logic [FN_LX_W-1:0] r3_len,
    input  logic [FN_LX_W-1:0] r4_len,
    input  logic [1:0]         ratio_mode,
    input  logic [FN_ST_W-1:0] frac_step,
    input  logic               mod8_sel,
    output logic [1:0]         mod_ctl,
    output logic               div_out,
    output logic [FN_ST_W-1:0] frac_acc,
    output logic               load_window
);
    fn_cfg_t cfg_in, cfg_w;
    logic    reload, carry, cyc_end;

    assign cfg_in = '{len1: r1_len, len2: r2_len, len3: r3_len, len4: r4_len,
                      mode: ratio_mode, step: frac_step, mod8: mod8_sel};

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_w <= '0;
        else if (reload) cfg_w <= cfg_in;
    end

    fn_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (div_en),
        .len2_w   (cfg_w.len2),
        .len3_w   (cfg_w.len3),
        .len4_w   (cfg_w.len4),
        .mode_w   (cfg_w.mode),
        .len1_nx  (r1_len),
        .carry_in (carry),
        .mod_ctl  (mod_ctl),
        .cyc_end  (cyc_end),
        .window   (load_window),
        .reload   (reload)
    );

    fn_frac_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .step  (cyc_end),
        .inc   (cfg_w.step),
        .mod8  (cfg_w.mod8),
        .acc   (frac_acc),
        .carry (carry)
    );

    assign div_out = cyc_end;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_w) |-> $past(reload));                     // R9
endmodule

// File: tb/fn_main_divider_test.sv
module fn_main_divider_test;
    import fn_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic [1:0] mc;
        logic       pulse;
        int         acc;
        logic       win;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               div_en = 1'b0;
    logic [FN_L1_W-1:0] r1_len = '0;
    logic [FN_L2_W-1:0] r2_len = '0;
    logic [FN_LX_W-1:0] r3_len = '0;
    logic [FN_LX_W-1:0] r4_len = '0;
    logic [1:0]         ratio_mode = '0;
    logic [FN_ST_W-1:0] frac_step = '0;
    logic               mod8_sel = 1'b0;
    logic [1:0]         mod_ctl;
    logic               div_out;
    logic [FN_ST_W-1:0] frac_acc;
    logic               load_window;

    exp_t  exp_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    mon_on = 0, done = 0;
    int    cyc_idx = 0, r2_cnt = 0, avg_lim = 0;
    string cur_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    fn_main_divider uut (.*);

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (mon_on && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk({cur_tag, " R3 mod_ctl"}, int'(mod_ctl), int'(e.mc));
            chk({cur_tag, " R7 div_out"}, int'(div_out), int'(e.pulse));
            chk({cur_tag, " R8 frac_acc"}, int'(frac_acc), e.acc);
            chk({cur_tag, " R10 load_window"}, int'(load_window), int'(e.win));
            if (mod_ctl == 2'b00 && cyc_idx >= 1 && cyc_idx <= avg_lim) r2_cnt++;
            if (div_out) cyc_idx++;
        end
    end

    // model of one divider cycle built from R2, R4, R5, R6 and R10
    task automatic push_cycle(fn_cfg_t c, bit ovf, int acc);
        int len[4];
        int last_ph = 0, total = 0, pos = 0;
        int l2;
        exp_t e;
        l2     = (c.mode == 2'b01) ? int'(c.len2) : int'(c.len2[3:0]);
        len[0] = int'(c.len1) + 2 - int'(ovf);
        len[1] = l2 + int'(ovf);
        len[2] = c.mode[1] ? int'(c.len3) + 1 : 0;
        len[3] = (c.mode[1] == c.mode[0]) ? int'(c.len4) + 1 : 0;
        for (int p = 0; p < 4; p++) begin
            if (len[p] > 0) last_ph = p;
            total += len[p];
        end
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < len[p]; i++) begin
                pos++;
                e.mc    = (p == 0) ? 2'b10 : (p == 1) ? 2'b00 : (p == 2) ? 2'b01 : 2'b11;
                e.pulse = (pos == total);
                e.acc   = acc;
                e.win   = (p == last_ph) && (pos != total);
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic drive(fn_cfg_t c);
        r1_len = c.len1; r2_len = c.len2; r3_len = c.len3; r4_len = c.len4;
        ratio_mode = c.mode; frac_step = c.step; mod8_sel = c.mod8;
    endtask

    task automatic idle_check(string tag);
        chk({tag, " R1 idle mod_ctl"}, int'(mod_ctl), 2);
        chk({tag, " R1 idle div_out"}, int'(div_out), 0);
        chk({tag, " R1 idle frac_acc"}, int'(frac_acc), 0);
        chk({tag, " R1 idle load_window"}, int'(load_window), 0);
    endtask

    task automatic run(string tag, fn_cfg_t a, fn_cfg_t b, int ncyc, int chg_at,
                       int avg_q, int avg_exp);
        int acc = 0;
        bit ovf = 0;
        for (int k = 0; k < ncyc; k++) begin
            fn_cfg_t c;
            int q, s;
            c = (k == 0) ? a : b;
            push_cycle(c, ovf, acc);
            q   = c.mod8 ? 8 : 5;
            s   = (acc % q) + (int'(c.step) % q);
            ovf = (s >= q);
            acc = s % q;
        end
        @(negedge clk);
        drive(a);
        div_en = 1'b1;
        cur_tag = tag; cyc_idx = 0; r2_cnt = 0; avg_lim = avg_q;
        @(posedge clk);
        mon_on = 1;
        if (chg_at > 0) begin
            repeat (chg_at) @(negedge clk);
            drive(b);
        end
        wait (exp_q.size() == 0);
        @(posedge clk);
        mon_on = 0;
        if (avg_q > 0) chk({tag, " R11 R2 clocks per modulus period"}, r2_cnt, avg_exp);
        @(negedge clk);
        div_en = 1'b0;
        @(negedge clk);
        idle_check(tag);
    endtask

    initial begin
        fn_cfg_t a, b;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("reset");

        // R2 R5 R11: mode 01 uses full 8-bit R2 length, Q=5, step 2
        a = '{len1: 12'd4, len2: 8'h12, len3: 4'd0, len4: 4'd0, mode: 2'b01, step: 3'd2, mod8: 1'b0};
        run("R2 R5 mode01", a, a, 7, 0, 5, 5*18 + 2);

        // R2 R5 R6 R11: mode 11 all phases, R2 length masked to 4 bits, Q=8
        a = '{len1: 12'd3, len2: 8'h25, len3: 4'd2, len4: 4'd1, mode: 2'b11, step: 3'd3, mod8: 1'b1};
        run("R2 R5 R6 mode11", a, a, 10, 0, 8, 8*5 + 3);

        // R8 R11: mode 10, step 6 reduced modulo 5 to 1
        a = '{len1: 12'd2, len2: 8'd2, len3: 4'd3, len4: 4'd0, mode: 2'b10, step: 3'd6, mod8: 1'b0};
        run("R8 mode10 step-reduce", a, a, 6, 0, 5, 5*2 + 1);

        // R4 R6: mode 00, zero R2 length skipped except in carry cycles
        a = '{len1: 12'd1, len2: 8'd0, len3: 4'd0, len4: 4'd2, mode: 2'b00, step: 3'd1, mod8: 1'b1};
        run("R4 R6 mode00 empty-R2", a, a, 9, 0, 8, 1);

        // R9: reprogramming three clocks into the first cycle only acts on the next
        a = '{len1: 12'd6, len2: 8'd2, len3: 4'd0, len4: 4'd0, mode: 2'b01, step: 3'd4, mod8: 1'b0};
        b = '{len1: 12'd2, len2: 8'd1, len3: 4'd1, len4: 4'd0, mode: 2'b11, step: 3'd1, mod8: 1'b1};
        run("R9 reprogram", a, b, 5, 3, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", exp_q.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule